// File: doc/BRIEF.md
# Asymmetric Dual-Issue Dispatcher

This block picks, every clock, which decoded instructions leave the heads of two hardware-thread instruction queues for a core with two typed execution ports: one scalar ALU port and one vector port. The vector port serves an 8-lane SIMD unit. The two ports differ in type. A cycle can issue two instructions only as one scalar plus one vector. The pair can come from a single thread, which is superscalar issue. It can also come from one thread on each port, which is simultaneous multithreading.

Each thread presents its two oldest queue entries. Each entry carries a valid bit, a class bit, a destination tag, a source tag and an opaque opcode payload. The dispatcher decides issue without delay. In the same cycle it drives a per-port issue strobe with the chosen entry's fields and owning thread. It also drives a per-thread pop count that tells each queue how far to advance. The only state it holds is a round-robin pointer that gives first choice between the two threads.

Top module: `dual_issue_dispatch`

## Requirements
- R1: With no valid oldest entry in either thread, neither port issues and both pop counts are 0. Out of reset the round-robin pointer favours thread 0.
- R2: A port issues at most one instruction per cycle. Class bit 0 means scalar and goes only to the scalar port. Class bit 1 means vector and goes only to the vector port. Two ready instructions of the same class never issue in the same cycle.
- R3: When the first-choice thread's two entries have different classes and are independent, both issue from that thread in the same cycle.
- R4: Within one thread, the younger entry depends on the older one when its source tag equals the older entry's destination tag. A dependent younger entry does not issue, and only the older one does.
- R5: Issue within a thread is in order. Entry 1 (younger) issues only in a cycle where entry 0 of the same thread also issues. A valid entry 1 behind an invalid entry 0 never issues.
- R6: When the first-choice thread fills only one port, the other thread's entry 0 takes the remaining port if its class matches that port.
- R7: When both threads have a valid entry 0, the pointer-selected thread always issues its entry 0. The pointer flips after every such cycle. When only one thread has a valid entry 0, that thread gets first choice and the pointer holds.
- R8: Pop count per thread (2 bits, thread t at bits [2t+1:2t]) equals the number of instructions issued from that thread in that cycle. Stalled entries are not popped.
- R9: Each issuing port carries the destination tag, source tag and opcode of the chosen entry, plus its thread id (0 or 1). Entry index is thread*2+slot, with slot 0 the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 4 | Entry valid, index thread*2+slot |
| cls_i | input | 4 | Entry class, 0 scalar, 1 vector |
| dst_i | input | 4*TAG_W | Destination tags per entry |
| src_i | input | 4*TAG_W | Source tags per entry |
| op_i | input | 4*OP_W | Opcode payload per entry |
| sc_issue_o | output | 1 | Scalar port issue strobe |
| sc_tid_o | output | 1 | Thread owning scalar issue |
| sc_dst_o | output | TAG_W | Scalar issue destination tag |
| sc_src_o | output | TAG_W | Scalar issue source tag |
| sc_op_o | output | OP_W | Scalar issue opcode |
| vec_issue_o | output | 1 | Vector port issue strobe |
| vec_tid_o | output | 1 | Thread owning vector issue |
| vec_dst_o | output | TAG_W | Vector issue destination tag |
| vec_src_o | output | TAG_W | Vector issue source tag |
| vec_op_o | output | OP_W | Vector issue opcode |
| pop_cnt_o | output | 4 | Per-thread pop count, 2 bits each |

## Verification
The round-robin pointer is the only register. A wrong pointer value shows up in the first cycle where both threads are valid and cannot share the ports. The wrong thread's tid then appears on the contended port, and the pop counts move to the wrong queue in that same cycle. A pop count that does not match the issues made would desynchronise a queue at once. The mismatch is visible without delay, because pops, strobes and tids are all combinational in one cycle.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int NUM_THR = 2;
  localparam int SLOTS   = 2;
  localparam int ENTRIES = NUM_THR * SLOTS;

  typedef enum logic {
    CLS_SCALAR = 1'b0,
    CLS_VECTOR = 1'b1
  } iclass_e;
endpackage

// File: rtl/dispatch_thread_cand.sv
module dispatch_thread_cand
  import dispatch_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic [SLOTS-1:0] vld_i,
  input  logic [SLOTS-1:0] cls_i,
  input  logic [TAG_W-1:0] old_dst_i,
  input  logic [TAG_W-1:0] yng_src_i,
  output logic             head_vld_o,
  output logic             head_cls_o,
  output logic             pair_ok_o
);
  logic raw_hazard;

  assign raw_hazard = (yng_src_i == old_dst_i);
  assign head_vld_o = vld_i[0];
  assign head_cls_o = cls_i[0];
  // pair needs both valid, opposite classes, no RAW between them
  assign pair_ok_o  = vld_i[0] && vld_i[1] && (cls_i[0] != cls_i[1]) && !raw_hazard;
endmodule

// File: rtl/dispatch_rr_arb.sv
module dispatch_rr_arb
  import dispatch_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] head_vld_i,
  output logic               prio_o,
  output logic               rr_q_o
);
  logic rr_q;
  logic both;

  assign both = &head_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rr_q <= 1'b0;
    else if (both) rr_q <= ~rr_q;
  end

  always_comb begin
    if (both)               prio_o = rr_q;
    else if (head_vld_i[1]) prio_o = 1'b1;
    else                    prio_o = 1'b0;
  end

  assign rr_q_o = rr_q;
endmodule

// File: rtl/dispatch_issue_ctl.sv
module dispatch_issue_ctl
  import dispatch_pkg::*;
(
  input  logic [NUM_THR-1:0]      head_vld_i,
  input  logic [NUM_THR-1:0]      head_cls_i,
  input  logic [NUM_THR-1:0]      pair_ok_i,
  input  logic                    prio_i,
  output logic                    sc_iss_o,
  output logic [1:0]              sc_idx_o,
  output logic                    vec_iss_o,
  output logic [1:0]              vec_idx_o,
  output logic [NUM_THR-1:0][1:0] pop_o
);
  logic       p, q, any;
  logic [1:0] first_idx, second_idx;
  logic       second_vld;

  always_comb begin
    p          = prio_i;
    q          = ~prio_i;
    any        = |head_vld_i;
    first_idx  = {p, 1'b0};
    second_idx = '0;
    second_vld = 1'b0;
    pop_o      = '0;
    if (any) begin
      pop_o[p] = 2'd1;
      if (pair_ok_i[p]) begin
        second_vld = 1'b1;
        second_idx = {p, 1'b1};
        pop_o[p]   = 2'd2;
      end else if (head_vld_i[q] && (head_cls_i[q] != head_cls_i[p])) begin
        second_vld = 1'b1;
        second_idx = {q, 1'b0};
        pop_o[q]   = 2'd1;
      end
    end
    if (head_cls_i[p] == CLS_VECTOR) begin
      vec_iss_o = any;        vec_idx_o = first_idx;
      sc_iss_o  = second_vld; sc_idx_o  = second_idx;
    end else begin
      sc_iss_o  = any;        sc_idx_o  = first_idx;
      vec_iss_o = second_vld; vec_idx_o = second_idx;
    end
  end
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dispatch_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int OP_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ENTRIES-1:0]       vld_i,
  input  logic [ENTRIES-1:0]       cls_i,
  input  logic [ENTRIES*TAG_W-1:0] dst_i,
  input  logic [ENTRIES*TAG_W-1:0] src_i,
  input  logic [ENTRIES*OP_W-1:0]  op_i,
  output logic                     sc_issue_o,
  output logic                     sc_tid_o,
  output logic [TAG_W-1:0]         sc_dst_o,
  output logic [TAG_W-1:0]         sc_src_o,
  output logic [OP_W-1:0]          sc_op_o,
  output logic                     vec_issue_o,
  output logic                     vec_tid_o,
  output logic [TAG_W-1:0]         vec_dst_o,
  output logic [TAG_W-1:0]         vec_src_o,
  output logic [OP_W-1:0]          vec_op_o,
  output logic [2*NUM_THR-1:0]     pop_cnt_o
);
  logic [NUM_THR-1:0]      head_vld, head_cls, pair_ok;
  logic                    prio, rr_q;
  logic [1:0]              sc_idx, vec_idx;
  logic [NUM_THR-1:0][1:0] pop;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    dispatch_thread_cand #(.TAG_W(TAG_W)) u_cand (
      .vld_i      (vld_i[t*SLOTS +: SLOTS]),
      .cls_i      (cls_i[t*SLOTS +: SLOTS]),
      .old_dst_i  (dst_i[(t*SLOTS)*TAG_W +: TAG_W]),
      .yng_src_i  (src_i[(t*SLOTS+1)*TAG_W +: TAG_W]),
      .head_vld_o (head_vld[t]),
      .head_cls_o (head_cls[t]),
      .pair_ok_o  (pair_ok[t])
    );
    assign pop_cnt_o[2*t +: 2] = pop[t];
  end

  dispatch_rr_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_vld_i (head_vld),
    .prio_o     (prio),
    .rr_q_o     (rr_q)
  );

  dispatch_issue_ctl u_ctl (
    .head_vld_i (head_vld),
    .head_cls_i (head_cls),
    .pair_ok_i  (pair_ok),
    .prio_i     (prio),
    .sc_iss_o   (sc_issue_o),
    .sc_idx_o   (sc_idx),
    .vec_iss_o  (vec_issue_o),
    .vec_idx_o  (vec_idx),
    .pop_o      (pop)
  );

  assign sc_tid_o  = sc_idx[1];
  assign sc_dst_o  = dst_i[sc_idx*TAG_W +: TAG_W];
  assign sc_src_o  = src_i[sc_idx*TAG_W +: TAG_W];
  assign sc_op_o   = op_i[sc_idx*OP_W +: OP_W];
  assign vec_tid_o = vec_idx[1];
  assign vec_dst_o = dst_i[vec_idx*TAG_W +: TAG_W];
  assign vec_src_o = src_i[vec_idx*TAG_W +: TAG_W];
  assign vec_op_o  = op_i[vec_idx*OP_W +: OP_W];
endmodule

// File: rtl/dual_issue_dispatch_chk.sv
module dual_issue_dispatch_chk
  import dispatch_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ENTRIES-1:0]       vld_i,
  input logic [ENTRIES*TAG_W-1:0] dst_i,
  input logic [ENTRIES*TAG_W-1:0] src_i,
  input logic                     sc_issue_o,
  input logic                     sc_tid_o,
  input logic                     vec_issue_o,
  input logic                     vec_tid_o,
  input logic [2*NUM_THR-1:0]     pop_cnt_o,
  input logic                     rr_q
);
  logic             both_heads, no_heads, same_thr_pair;
  logic [2:0]       pop_sum, iss_sum;
  logic [1:0]       pop_of_tid;
  logic [TAG_W-1:0] old_dst, yng_src;

  assign both_heads    = vld_i[0] && vld_i[2];
  assign no_heads      = !vld_i[0] && !vld_i[2];
  assign same_thr_pair = sc_issue_o && vec_issue_o && (sc_tid_o == vec_tid_o);
  assign pop_sum       = {1'b0, pop_cnt_o[1:0]} + {1'b0, pop_cnt_o[3:2]};
  assign iss_sum       = {2'b0, sc_issue_o} + {2'b0, vec_issue_o};
  assign pop_of_tid    = sc_tid_o ? pop_cnt_o[3:2] : pop_cnt_o[1:0];
  assign old_dst       = dst_i[{sc_tid_o, 1'b0}*TAG_W +: TAG_W];
  assign yng_src       = src_i[{sc_tid_o, 1'b1}*TAG_W +: TAG_W];

  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_heads |-> (!sc_issue_o && !vec_issue_o && pop_cnt_o == '0));

  a_r8_pop_matches_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_sum == iss_sum);

  a_r3_pair_pops_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same_thr_pair |-> pop_of_tid == 2'd2);

  a_r4_pair_independent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same_thr_pair |-> yng_src != old_dst);

  a_r6_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !no_heads |-> (sc_issue_o || vec_issue_o));

  a_r7_ptr_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_heads |=> rr_q != $past(rr_q));

  a_r7_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both_heads |=> $stable(rr_q));
endmodule

bind dual_issue_dispatch dual_issue_dispatch_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vld_i       (vld_i),
  .dst_i       (dst_i),
  .src_i       (src_i),
  .sc_issue_o  (sc_issue_o),
  .sc_tid_o    (sc_tid_o),
  .vec_issue_o (vec_issue_o),
  .vec_tid_o   (vec_tid_o),
  .pop_cnt_o   (pop_cnt_o),
  .rr_q        (rr_q)
);

// File: tb/dual_issue_dispatch_bench.sv
module dual_issue_dispatch_bench;
  localparam int TAG_W = 5;
  localparam int OP_W  = 12;
  localparam int N_RND = 4000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        vld = '0, cls = '0;
  logic [4*TAG_W-1:0] dst = '0, src = '0;
  logic [4*OP_W-1:0]  op = '0;
  logic              sc_iss, sc_tid, vec_iss, vec_tid;
  logic [TAG_W-1:0]  sc_dst, sc_src, vec_dst, vec_src;
  logic [OP_W-1:0]   sc_op, vec_op;
  logic [3:0]        pop_cnt;

  int n_chk = 0, n_fail = 0;
  bit m_rr = 1'b0;

  always #2 clk = ~clk;

  dual_issue_dispatch #(.TAG_W(TAG_W), .OP_W(OP_W)) u_dual_issue_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .cls_i(cls), .dst_i(dst),
    .src_i(src), .op_i(op), .sc_issue_o(sc_iss), .sc_tid_o(sc_tid),
    .sc_dst_o(sc_dst), .sc_src_o(sc_src), .sc_op_o(sc_op),
    .vec_issue_o(vec_iss), .vec_tid_o(vec_tid), .vec_dst_o(vec_dst),
    .vec_src_o(vec_src), .vec_op_o(vec_op), .pop_cnt_o(pop_cnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [TAG_W-1:0] tag_of(input logic [4*TAG_W-1:0] v, input int i);
    return v[i*TAG_W +: TAG_W];
  endfunction

  // reference model computed from the requirements
  task automatic model(output bit e_sc, output int e_sc_i, output bit e_vec,
                       output int e_vec_i, output int e_pop0, output int e_pop1);
    int p, q, first, second;
    bit any, pair, sec_v;
    int pops[2];
    pops = '{0, 0};
    any = vld[0] || vld[2];
    if (vld[0] && vld[2]) p = m_rr;
    else if (vld[2])      p = 1;
    else                  p = 0;
    q = 1 - p;
    first = p*2; second = 0; sec_v = 0;
    pair = vld[p*2] && vld[p*2+1] && (cls[p*2] != cls[p*2+1])
           && (tag_of(src, p*2+1) != tag_of(dst, p*2));
    if (any) begin
      pops[p] = 1;
      if (pair) begin sec_v = 1; second = p*2+1; pops[p] = 2; end
      else if (vld[q*2] && cls[q*2] != cls[p*2]) begin
        sec_v = 1; second = q*2; pops[q] = 1;
      end
    end
    if (cls[p*2]) begin e_vec = any; e_vec_i = first; e_sc = sec_v; e_sc_i = second; end
    else          begin e_sc = any;  e_sc_i = first;  e_vec = sec_v; e_vec_i = second; end
    e_pop0 = pops[0]; e_pop1 = pops[1];
  endtask

  // apply at negedge, compare 1 ns later, advance model pointer
  task automatic step(input logic [3:0] v, input logic [3:0] c,
                      input logic [4*TAG_W-1:0] d, input logic [4*TAG_W-1:0] s,
                      input logic [4*OP_W-1:0] o);
    bit e_sc, e_vec;
    int e_sc_i, e_vec_i, e_p0, e_p1;
    @(negedge clk);
    vld = v; cls = c; dst = d; src = s; op = o;
    #1;
    model(e_sc, e_sc_i, e_vec, e_vec_i, e_p0, e_p1);
    chk("R2 scalar strobe", sc_iss, e_sc);
    chk("R2 vector strobe", vec_iss, e_vec);
    chk("R8 pop t0", pop_cnt[1:0], e_p0);
    chk("R8 pop t1", pop_cnt[3:2], e_p1);
    if (e_sc) begin
      chk("R9 scalar tid", sc_tid, e_sc_i / 2);
      chk("R9 scalar dst", sc_dst, tag_of(dst, e_sc_i));
      chk("R9 scalar src", sc_src, tag_of(src, e_sc_i));
      chk("R9 scalar op", sc_op, op[e_sc_i*OP_W +: OP_W]);
    end
    if (e_vec) begin
      chk("R9 vector tid", vec_tid, e_vec_i / 2);
      chk("R9 vector dst", vec_dst, tag_of(dst, e_vec_i));
      chk("R9 vector src", vec_src, tag_of(src, e_vec_i));
      chk("R9 vector op", vec_op, op[e_vec_i*OP_W +: OP_W]);
    end
    if (vld[0] && vld[2]) m_rr = ~m_rr;
  endtask

  // tags packed as {e3,e2,e1,e0}
  function automatic logic [4*TAG_W-1:0] tg(input int a3, input int a2, input int a1, input int a0);
    return {TAG_W'(a3), TAG_W'(a2), TAG_W'(a1), TAG_W'(a0)};
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [4*OP_W-1:0] ops;
    void'($urandom(32'd2024));
    ops = {12'hD33, 12'hC22, 12'hB11, 12'hA00};
    #7 rst_n = 1'b1;

    // R1: idle after reset
    step(4'b0000, 4'b0000, '0, '0, ops);
    chk("R1 idle no scalar", sc_iss, 0);
    chk("R1 idle no vector", vec_iss, 0);
    chk("R1 idle pops", pop_cnt, 0);

    // R3: thread 0 scalar + vector, independent
    step(4'b0011, 4'b0010, tg(0,0,2,1), tg(0,0,3,0), ops);
    chk("R3 dual scalar", sc_iss, 1);
    chk("R3 dual vector", vec_iss, 1);
    chk("R3 pop two", pop_cnt[1:0], 2);

    // R2: two scalars in thread 0, only oldest goes
    step(4'b0011, 4'b0000, tg(0,0,2,1), tg(0,0,3,0), ops);
    chk("R2 same class vector idle", vec_iss, 0);
    chk("R2 same class pop one", pop_cnt[1:0], 1);

    // R4: younger src equals older dst
    step(4'b0011, 4'b0010, tg(0,0,2,7), tg(0,0,7,0), ops);
    chk("R4 dependent vector held", vec_iss, 0);
    chk("R4 dependent pop one", pop_cnt[1:0], 1);

    // R5: entry1 valid behind invalid entry0 in both threads
    step(4'b1010, 4'b1010, tg(1,2,3,4), tg(5,6,7,8), ops);
    chk("R5 no scalar", sc_iss, 0);
    chk("R5 no vector", vec_iss, 0);

    // R6: thread 1 alone vector head, thread 0 scalar head -> SMT share
    step(4'b0101, 4'b0100, tg(0,3,0,2), tg(0,0,0,0), ops);
    chk("R6 smt scalar tid", sc_tid, 0);
    chk("R6 smt vector tid", vec_tid, 1);

    // R7: contention on vector port alternates threads
    begin
      bit first_tid;
      step(4'b0101, 4'b0101, '0, '0, ops);
      first_tid = vec_tid;
      step(4'b0101, 4'b0101, '0, '0, ops);
      chk("R7 alternation", vec_tid, !first_tid);
      step(4'b0101, 4'b0101, '0, '0, ops);
      chk("R7 alternation back", vec_tid, first_tid);
    end

    // R7: single valid thread holds pointer
    step(4'b0100, 4'b0100, '0, '0, ops);
    chk("R7 lone thread1", vec_tid, 1);

    for (int i = 0; i < N_RND; i++) begin
      logic [4*TAG_W-1:0] d, s;
      for (int k = 0; k < 4; k++) begin
        d[k*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 3));
        s[k*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 3));
      end
      step(4'($urandom), 4'($urandom), d, s, (4*OP_W)'({$urandom, $urandom}));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule